// File: doc/BRIEF.md
# Parallel NOR Flash Command Front End

This block is the front end of a parallel NOR flash device, sitting over an internal byte-addressed storage array. Every bus write is decoded as one step of a multi-cycle command sequence. The low byte of the write data carries the command code, except in data cycles, where the whole word is payload. The sequences cover returning to array reads, single-word program, sector erase with confirm, status clear, status read, identification query, counted buffered write, and lock/unlock. Lock/unlock is accepted but has no protective effect.

Each bus read is served from one of three sources, chosen by the active command: the storage array, the 8-bit status register (bit 7 is the ready flag), or a computed query table. Read data is registered and appears one clock after the request. Sector erase is a sweep that fills one 32-bit word with 0xFF per clock. While the sweep runs, the ready flag is low and bus writes are dropped.

Top module: `nor_cmd_front`

## Requirements
- R1: After reset the device is in array-read mode, `rdata_o` is zero, and the status register reads 0x00.
- R2: Array accesses carry 1, 2 or 4 bytes, selected by `size_i` = 0, 1 or 2. With `big_endian_i`=0 the lowest address holds data bits [7:0]. With `big_endian_i`=1 the lowest address holds the most significant byte of the access. Unused upper read bits are zero.
- R3: Code 0x50, written as a first cycle, clears the status register to 0x00 and returns to array reads.
- R4: After code 0x10 or 0x40, the next write stores its data at its address using the R2 packing. Status bit 7 is then 1, and reads return status until 0xFF is written.
- R5: Code 0x20 erases the sector of SECTOR_BYTES that contains the write address, filling it with 0xFF over SECTOR_BYTES/4 clocks. Status reads 0x00 while the erase runs and 0x80 when it ends. Writes issued during the erase are dropped.
- R6: The write after an erase completes is checked for a confirm code. 0xD0 keeps status reads, with status 0x80. 0xFF or any other code returns to array reads.
- R7: Code 0xE8 sets status bit 7 at once. The next write loads a count N from its low CNT_W bits. The following N+1 writes store data words. The write after those must be 0xD0, which keeps status reads. Any other code there returns to array reads and stores nothing.
- R8: After code 0x60, a second write of 0xD0 or 0x01 sets status bit 7 and keeps status reads. Any other second code returns to array reads.
- R9: Reads return the status register, zero-extended, under every active command other than idle (0x00) and query. Code 0x70 does not open a sequence, so the next write is decoded as a new first cycle.
- R10: In query mode (0x98), the table offset is the low address byte shifted right by log2(DEV_BYTES). Offsets 0x10, 0x11 and 0x12 read 0x51, 0x52 and 0x59. Offset 0x27 reads log2 of the total bytes. Offset 0x2D reads NUM_SECTORS-1. Offsets of 0x52 and above read zero. Writes other than 0xFF keep query mode, and 0xFF leaves it.
- R11: An unrecognised first-cycle code returns to array reads and leaves the array unchanged.
- R12: 0x00 or 0xFF written as a first cycle returns to array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| big_endian_i | input | 1 | Static byte order for multi-byte array accesses |
| addr_i | input | AW | Byte address of the request |
| wdata_i | input | 32 | Write data; low byte is the command code |
| size_i | input | 2 | Access size: 0=1 byte, 1=2 bytes, 2=4 bytes |
| we_i | input | 1 | Write strobe, one cycle per bus write |
| re_i | input | 1 | Read strobe, one cycle per bus read |
| rdata_o | output | 32 | Registered read data, valid the cycle after `re_i` |

## Verification
The hardest state to reach is a write arriving in the middle of an erase sweep. The window lasts only SECTOR_BYTES/4 clocks after the erase code and is invisible at the ports except through the status value. The stimulus sends a clear-status code a few cycles into the first erase. It then shows that the code was dropped, because status still reads 0x80 once the sweep ends. The counted buffered write has its own boundary cases: a zero count, and a confirm code placed where an extra data word would land. The stimulus drives both and compares the array afterwards against a reference byte model.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [1:0] {WC_IDLE, WC_ARG, WC_DATA, WC_CONFIRM} wcyc_e;
  typedef enum logic [1:0] {SRC_ARRAY, SRC_STATUS, SRC_QUERY} rsrc_e;

  localparam logic [7:0] OP_NOP      = 8'h00;
  localparam logic [7:0] OP_LOCK_ALT = 8'h01;
  localparam logic [7:0] OP_PROG_A   = 8'h10;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_PROG_B   = 8'h40;
  localparam logic [7:0] OP_CLR      = 8'h50;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_STAT     = 8'h70;
  localparam logic [7:0] OP_QUERY    = 8'h98;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_BUF      = 8'hE8;
  localparam logic [7:0] OP_ARRAY    = 8'hFF;

  localparam logic [7:0] QRY_LEN     = 8'h52;

  function automatic int size_bytes(logic [1:0] s);
    return (s == 2'd0) ? 1 : ((s == 2'd1) ? 2 : 4);
  endfunction
endpackage

// File: rtl/nor_byte_array.sv
module nor_byte_array
  import nor_cmd_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                 clk_i,
  input  logic                 big_endian_i,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [BUS_W-1:0]     wr_data_i,
  input  logic [1:0]           wr_size_i,
  input  logic                 fill_en_i,
  input  logic [AW-3:0]        fill_word_i,
  input  logic [AW-1:0]        rd_addr_i,
  input  logic [1:0]           rd_size_i,
  output logic [BUS_W-1:0]     rd_data_o
);
  localparam int DEPTH = 1 << AW;
  localparam int LANES = BUS_W / 8;

  logic [7:0] mem_q [DEPTH];
  logic [7:0] wr_byte [LANES];
  logic [LANES-1:0] wr_mask;

  always_comb begin
    int wn;
    wn = size_bytes(wr_size_i);
    for (int k = 0; k < LANES; k++) begin
      int idx;
      idx = big_endian_i ? (wn - 1 - k) : k;
      if (k >= wn) idx = 0;
      wr_byte[k] = wr_data_i[8*idx +: 8];
      wr_mask[k] = (k < wn);
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      for (int k = 0; k < LANES; k++) mem_q[{fill_word_i, 2'(k)}] <= 8'hFF;
    end else if (wr_en_i) begin
      for (int k = 0; k < LANES; k++)
        if (wr_mask[k]) mem_q[wr_addr_i + AW'(k)] <= wr_byte[k];
    end
  end

  always_comb begin
    int rn;
    rn = size_bytes(rd_size_i);
    rd_data_o = '0;
    for (int k = 0; k < LANES; k++) begin
      int idx;
      idx = big_endian_i ? (rn - 1 - k) : k;
      if (k < rn) rd_data_o[8*idx +: 8] = mem_q[rd_addr_i + AW'(k)];
    end
  end
endmodule

// File: rtl/nor_query_table.sv
module nor_query_table #(
  parameter int TOTAL_BYTES  = 256,
  parameter int SECTOR_BYTES = 64,
  parameter int NUM_SECTORS  = 4
) (
  input  logic [7:0] off_i,
  output logic [7:0] data_o
);
  localparam int TOTAL_LOG2 = $clog2(TOTAL_BYTES);

  always_comb begin
    data_o = 8'h00;
    if (off_i < nor_cmd_pkg::QRY_LEN) begin
      case (off_i)
        8'h10: data_o = 8'h51;
        8'h11: data_o = 8'h52;
        8'h12: data_o = 8'h59;
        8'h13: data_o = 8'h01;
        8'h15: data_o = 8'h31;
        8'h27: data_o = 8'(TOTAL_LOG2);
        8'h28: data_o = 8'h02;
        8'h2C: data_o = 8'h01;
        8'h2D: data_o = 8'(NUM_SECTORS - 1);
        8'h2E: data_o = 8'((NUM_SECTORS - 1) >> 8);
        8'h2F: data_o = 8'(SECTOR_BYTES >> 8);
        8'h30: data_o = 8'(SECTOR_BYTES >> 16);
        8'h31: data_o = 8'h50;
        8'h32: data_o = 8'h52;
        8'h33: data_o = 8'h49;
        default: data_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_cmd_pkg::*;
#(
  parameter int AW           = 8,
  parameter int SECTOR_BYTES = 64,
  parameter int CNT_W        = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [AW-1:0]    addr_i,
  output logic             prog_en_o,
  output logic             fill_en_o,
  output logic [AW-3:0]    fill_word_o,
  output rsrc_e            rsrc_o,
  output logic [7:0]       status_o
);
  localparam int SB   = $clog2(SECTOR_BYTES);
  localparam int SW   = SECTOR_BYTES / 4;
  localparam int SWW  = $clog2(SW);
  localparam logic [SWW-1:0] LAST_W = SWW'(SW - 1);

  wcyc_e             wc_q, wc_d;
  logic [7:0]        cmd_q, cmd_d;
  logic              rdy_q, rdy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              sweep_q, start_sweep;
  logic [SWW-1:0]    idx_q;
  logic [AW-SB-1:0]  sect_q;
  logic [7:0]        op;
  logic              wr_ok;

  assign op    = wdata_i[7:0];
  assign wr_ok = we_i && !sweep_q;

  assign prog_en_o = wr_ok && ((wc_q == WC_ARG && (cmd_q == OP_PROG_A || cmd_q == OP_PROG_B)) ||
                               (wc_q == WC_DATA && cmd_q == OP_BUF));
  assign fill_en_o   = sweep_q;
  assign fill_word_o = {sect_q, idx_q};
  assign status_o    = {rdy_q, 7'b0};

  always_comb begin
    rsrc_o = SRC_STATUS;
    if (cmd_q == OP_NOP)        rsrc_o = SRC_ARRAY;
    else if (cmd_q == OP_QUERY) rsrc_o = SRC_QUERY;
  end

  always_comb begin
    wc_d = wc_q; cmd_d = cmd_q; rdy_d = rdy_q; cnt_d = cnt_q; start_sweep = 1'b0;
    if (sweep_q && idx_q == LAST_W) rdy_d = 1'b1;
    if (wr_ok) begin
      // any fall-through below means error/abort: back to array reads
      case (wc_q)
        WC_IDLE: begin
          wc_d = WC_IDLE; cmd_d = OP_NOP;
          case (op)
            OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin cmd_d = op; wc_d = WC_ARG; end
            OP_ERASE: begin cmd_d = op; wc_d = WC_ARG; rdy_d = 1'b0; start_sweep = 1'b1; end
            OP_CLR:   rdy_d = 1'b0;
            OP_STAT:  cmd_d = op;
            OP_BUF:   begin cmd_d = op; wc_d = WC_ARG; rdy_d = 1'b1; end
            default:  ;
          endcase
        end
        WC_ARG: begin
          wc_d = WC_IDLE;
          case (cmd_q)
            OP_PROG_A, OP_PROG_B: begin rdy_d = 1'b1; cmd_d = OP_STAT; end
            OP_ERASE: if (op == OP_CONFIRM) rdy_d = 1'b1; else cmd_d = OP_NOP;
            OP_BUF:   begin cnt_d = wdata_i[CNT_W-1:0]; wc_d = WC_DATA; end
            OP_LOCK:  if (op == OP_CONFIRM || op == OP_LOCK_ALT) rdy_d = 1'b1; else cmd_d = OP_NOP;
            OP_QUERY: if (op == OP_ARRAY) cmd_d = OP_NOP; else wc_d = WC_ARG;
            default:  cmd_d = OP_NOP;
          endcase
        end
        WC_DATA: begin
          if (cmd_q == OP_BUF) begin
            rdy_d = 1'b1;
            cnt_d = cnt_q - 1'b1;
            if (cnt_q == '0) wc_d = WC_CONFIRM;
          end else begin
            wc_d = WC_IDLE; cmd_d = OP_NOP;
          end
        end
        default: begin
          wc_d = WC_IDLE;
          if (cmd_q == OP_BUF && op == OP_CONFIRM) rdy_d = 1'b1;
          else cmd_d = OP_NOP;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wc_q <= WC_IDLE; cmd_q <= OP_NOP; rdy_q <= 1'b0; cnt_q <= '0;
      sweep_q <= 1'b0; idx_q <= '0; sect_q <= '0;
    end else begin
      wc_q <= wc_d; cmd_q <= cmd_d; rdy_q <= rdy_d; cnt_q <= cnt_d;
      if (start_sweep) begin
        sweep_q <= 1'b1;
        idx_q   <= '0;
        sect_q  <= addr_i[AW-1:SB];
      end else if (sweep_q) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == LAST_W) sweep_q <= 1'b0;
      end
    end
  end

  AST_SWEEP_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_q |-> !status_o[7]); // R5
  AST_SWEEP_DONE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sweep_q) |-> status_o[7]); // R5
  AST_SWEEP_HOLDS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_q |=> ($stable(cmd_q) && $stable(wc_q))); // R5
  AST_CLEAR_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sweep_q && wc_q == WC_IDLE && op == OP_CLR) |=> (status_o == 8'h00 && rsrc_o == SRC_ARRAY)); // R3
  AST_PROGRAM_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_en_o && wc_q == WC_ARG) |=> (status_o[7] && rsrc_o == SRC_STATUS)); // R4
  AST_BUF_CONFIRM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sweep_q && wc_q == WC_CONFIRM && op == OP_CONFIRM) |=> (wc_q == WC_IDLE && status_o[7])); // R7
endmodule

// File: rtl/nor_cmd_front.sv
module nor_cmd_front
  import nor_cmd_pkg::*;
#(
  parameter int SECTOR_BYTES = 64,
  parameter int NUM_SECTORS  = 4,
  parameter int DEV_BYTES    = 2,
  parameter int CNT_W        = 8,
  parameter int TOTAL_BYTES  = SECTOR_BYTES * NUM_SECTORS,
  parameter int AW           = $clog2(TOTAL_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             big_endian_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [31:0]      wdata_i,
  input  logic [1:0]       size_i,
  input  logic             we_i,
  input  logic             re_i,
  output logic [31:0]      rdata_o
);
  localparam int QSH = (DEV_BYTES == 4) ? 2 : ((DEV_BYTES == 2) ? 1 : 0);

  logic             prog_en, fill_en;
  logic [AW-3:0]    fill_word;
  rsrc_e            rsrc;
  logic [7:0]       status;
  logic [31:0]      arr_rd;
  logic [7:0]       qoff, qdata;

  assign qoff = 8'(addr_i) >> QSH;

  nor_cmd_seq #(.AW(AW), .SECTOR_BYTES(SECTOR_BYTES), .CNT_W(CNT_W)) seq_i (
    .clk_i, .rst_ni, .we_i, .wdata_i, .addr_i,
    .prog_en_o(prog_en), .fill_en_o(fill_en), .fill_word_o(fill_word),
    .rsrc_o(rsrc), .status_o(status)
  );

  nor_byte_array #(.AW(AW)) array_i (
    .clk_i, .big_endian_i,
    .wr_en_i(prog_en), .wr_addr_i(addr_i), .wr_data_i(wdata_i), .wr_size_i(size_i),
    .fill_en_i(fill_en), .fill_word_i(fill_word),
    .rd_addr_i(addr_i), .rd_size_i(size_i), .rd_data_o(arr_rd)
  );

  nor_query_table #(.TOTAL_BYTES(TOTAL_BYTES), .SECTOR_BYTES(SECTOR_BYTES),
                    .NUM_SECTORS(NUM_SECTORS)) qtab_i (
    .off_i(qoff), .data_o(qdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (re_i) begin
      case (rsrc)
        SRC_ARRAY:  rdata_o <= arr_rd;
        SRC_STATUS: rdata_o <= {24'b0, status};
        SRC_QUERY:  rdata_o <= {24'b0, qdata};
        default:    rdata_o <= '0;
      endcase
    end
  end

  AST_QUERY_TAIL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && rsrc == SRC_QUERY && qoff >= QRY_LEN) |=> rdata_o == 32'h0); // R10
  AST_STATUS_ZERO_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && rsrc == SRC_STATUS) |=> rdata_o[31:8] == 24'h0); // R9
endmodule

// File: tb/nor_cmd_front_tb.sv
`timescale 1ns/1ps
module nor_cmd_front_tb_top;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        big_endian_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [1:0]  size_i = '0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [31:0] rdata_o;

  int unsigned vecs = 0, fails = 0;
  logic [7:0] ref_mem [256];
  bit done = 0;

  always #2.5 clk = ~clk;

  nor_cmd_front dut_i (.clk_i(clk), .rst_ni, .big_endian_i, .addr_i, .wdata_i,
                       .size_i, .we_i, .re_i, .rdata_o);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input int s);
    @(negedge clk);
    addr_i = AW'(a); wdata_i = d; size_i = 2'(s); we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input int a, input int s, output logic [31:0] d);
    @(negedge clk);
    addr_i = AW'(a); size_i = 2'(s); re_i = 1'b1;
    @(negedge clk);
    re_i = 1'b0;
    d = rdata_o;
  endtask

  function automatic int nb(input int s);
    return (s == 0) ? 1 : ((s == 1) ? 2 : 4);
  endfunction

  task automatic ref_store(input int a, input logic [31:0] d, input int s);
    int n = nb(s);
    for (int k = 0; k < n; k++)
      ref_mem[(a + k) & 255] = big_endian_i ? d[8*(n-1-k) +: 8] : d[8*k +: 8];
  endtask

  function automatic logic [31:0] ref_load(input int a, input int s);
    logic [31:0] v = '0;
    int n = nb(s);
    for (int k = 0; k < n; k++)
      if (big_endian_i) v[8*(n-1-k) +: 8] = ref_mem[(a + k) & 255];
      else              v[8*k +: 8]       = ref_mem[(a + k) & 255];
    return v;
  endfunction

  task automatic wait_ready(output bit ok);
    logic [31:0] d;
    ok = 0;
    for (int i = 0; i < 64; i++) begin
      rd(0, 0, d);
      if (d[7]) begin ok = 1; break; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit ok;
    repeat (3) @(negedge clk);
    check(rdata_o, 32'h0, "R1 rdata after reset");
    rst_ni = 1'b1;
    @(negedge clk);
    wr(0, 32'h70, 0); rd(0, 0, d);
    check(d, 32'h00, "R1 status after reset");

    // erase all sectors; first one also gets a dropped write mid-sweep
    for (int s = 0; s < 4; s++) begin
      wr(s*64 + 7, 32'h20, 0);
      rd(0, 0, d);
      check(d, 32'h00, "R5 status low during erase");
      if (s == 0) wr(0, 32'h50, 0);
      wait_ready(ok);
      check(32'(ok), 32'h1, "R5 erase completes");
      if (s == 0) begin
        rd(0, 0, d);
        check(d, 32'h80, "R5 write during sweep dropped");
      end
      wr(s*64, 32'hD0, 0);
      rd(0, 0, d);
      check(d, 32'h80, "R6 erase confirm keeps status");
      for (int k = 0; k < 64; k++) ref_mem[s*64 + k] = 8'hFF;
    end
    wr(0, 32'hFF, 0);
    for (int s = 0; s < 4; s++) begin
      rd(s*64, 2, d);      check(d, 32'hFFFF_FFFF, "R5 sector start erased");
      rd(s*64 + 60, 2, d); check(d, 32'hFFFF_FFFF, "R5 sector end erased");
    end

    // program/readback sweep over endianness and sizes
    for (int be = 0; be < 2; be++) begin
      big_endian_i = 1'(be);
      for (int i = 0; i < 8; i++) begin
        int a = 64 + be*32 + i*4;
        int sz = i % 3;
        logic [31:0] dat = 32'hA500_0000 + i*32'h0103_0507 + be*32'h0040_0000;
        wr(a, (i % 2) ? 32'h10 : 32'h40, 0);
        wr(a, dat, sz);
        ref_store(a, dat, sz);
        rd(0, 0, d);
        check(d, 32'h80, "R4 program ready");
        wr(0, 32'hFF, 0);
        for (int rs = 0; rs < 3; rs++) begin
          rd(a, rs, d);
          check(d, ref_load(a, rs), "R2 packed readback");
        end
      end
    end
    big_endian_i = 1'b0;

    // erase abort paths
    wr(70, 32'h20, 0); wait_ready(ok);
    wr(70, 32'hFF, 0);
    for (int k = 0; k < 64; k++) ref_mem[64 + k] = 8'hFF;
    rd(64, 2, d); check(d, 32'hFFFF_FFFF, "R6 erase aborted by FF reads array");
    wr(72, 32'h20, 0); wait_ready(ok);
    wr(72, 32'h33, 0);
    rd(68, 2, d); check(d, ref_load(68, 2), "R6 erase bad confirm reads array");

    // buffered write, count 3
    wr(0, 32'h50, 0);
    wr(200, 32'hE8, 0);
    rd(0, 0, d); check(d, 32'h80, "R7 buffer sets ready at once");
    wr(200, 32'd3, 0);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] dat = 32'h1122_3300 + i;
      wr(200 + i*4, dat, 2);
      ref_store(200 + i*4, dat, 2);
    end
    wr(216, 32'hD0, 0);
    rd(0, 0, d); check(d, 32'h80, "R7 buffer confirm status");
    wr(0, 32'hFF, 0);
    for (int i = 0; i < 5; i++) begin
      rd(200 + i*4, 2, d); check(d, ref_load(200 + i*4, 2), "R7 buffer contents");
    end
    // count 0 with bad confirm
    wr(220, 32'hE8, 0);
    wr(220, 32'd0, 0);
    wr(220, 32'hCAFE_0001, 2); ref_store(220, 32'hCAFE_0001, 2);
    wr(224, 32'h5A, 0);
    rd(220, 2, d); check(d, ref_load(220, 2), "R7 bad confirm returns to array");
    rd(224, 2, d); check(d, ref_load(224, 2), "R7 bad confirm stores nothing");

    // lock/unlock
    wr(0, 32'h50, 0); wr(0, 32'h60, 0); wr(0, 32'hD0, 0);
    rd(0, 0, d); check(d, 32'h80, "R8 lock D0 ready");
    wr(0, 32'h50, 0); wr(0, 32'h60, 0); wr(0, 32'h01, 0);
    rd(0, 0, d); check(d, 32'h80, "R8 lock 01 ready");
    wr(0, 32'h60, 0); wr(0, 32'h77, 0);
    rd(64, 2, d); check(d, ref_load(64, 2), "R8 unknown lock code reads array");

    // status read is single cycle
    wr(0, 32'h50, 0);
    wr(0, 32'h70, 0);
    rd(0, 0, d); check(d, 32'h00, "R9 status read");
    wr(232, 32'h10, 0);
    wr(232, 32'h0000_BEEF, 1); ref_store(232, 32'h0000_BEEF, 1);
    rd(0, 0, d); check(d, 32'h80, "R9 program after 0x70 decoded");
    wr(0, 32'hFF, 0);
    rd(232, 1, d); check(d, ref_load(232, 1), "R9 program data stored");

    // 0x00 returns to array
    wr(0, 32'h70, 0); wr(0, 32'h00, 0);
    rd(232, 1, d); check(d, ref_load(232, 1), "R12 0x00 reads array");

    // unknown first cycle
    wr(0, 32'h70, 0); wr(232, 32'h33, 0);
    rd(232, 1, d); check(d, ref_load(232, 1), "R11 unknown code reads array");

    // clear status
    wr(0, 32'h60, 0); wr(0, 32'hD0, 0);
    rd(0, 0, d); check(d, 32'h80, "R3 ready before clear");
    wr(0, 32'h50, 0);
    rd(200, 2, d); check(d, ref_load(200, 2), "R3 clear returns to array");
    wr(0, 32'h70, 0);
    rd(0, 0, d); check(d, 32'h00, "R3 status cleared");

    // query mode (DEV_BYTES=2: offset = addr >> 1)
    wr(0, 32'h98, 0);
    rd(8'h20, 0, d); check(d, 32'h51, "R10 query offset 0x10");
    rd(8'h22, 0, d); check(d, 32'h52, "R10 query offset 0x11");
    rd(8'h24, 0, d); check(d, 32'h59, "R10 query offset 0x12");
    rd(8'h4E, 0, d); check(d, 32'd8,  "R10 query size log2");
    rd(8'h5A, 0, d); check(d, 32'd3,  "R10 query sectors-1");
    rd(8'hA4, 0, d); check(d, 32'h0,  "R10 query offset 0x52 zero");
    rd(8'hFE, 0, d); check(d, 32'h0,  "R10 query top offset zero");
    wr(0, 32'h00, 0);
    rd(8'h20, 0, d); check(d, 32'h51, "R10 non-FF keeps query");
    wr(0, 32'hFF, 0);
    rd(200, 2, d); check(d, ref_load(200, 2), "R10 FF leaves query");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule